// File: doc/BRIEF.md
# Instruction Trace Filter Controller

This block decides, item by item, whether a retired instruction or an exception is sent into the instruction trace. It holds one 32-bit control word. The word contains an enable mask of exception levels for each security state, a start/stop state bit, two override bits, and an 8-bit event selector that is only stored. Software reaches the word through a simple register port at offset 0x080. The port accepts writes only while the trace unit enable is low.

Each cycle the core presents one item: a valid strobe, the exception level, the security state, and two flags that mark a system-error exception or a reset exception. `trace_hit` gives the decision for that item in the same cycle. A one-bit history register records whether the last valid item was traced. The override rules for reset and system-error exceptions depend on that bit.

Top module: `itrace_filter`

## Requirements
- R1: After reset the control word is zero, a read at 0x080 returns 0, and `trace_hit` is 0.
- R2: A write to 0x080 with `trace_en`=0 stores only the writable bits 22:20, 19, 17:16, 11:9 and 7:0 (mask 0x007B0EFF). A read at 0x080 returns the stored word, and all other bits read as zero.
- R3: A write to any other address changes nothing. A read from any other address returns 0.
- R4: A write is ignored while `trace_en`=1.
- R5: A Non-secure item (`item_ns`=1) that is an ordinary instruction can be traced at EL0, EL1 and EL2, enabled by bits 20, 21 and 22. It is never traced at EL3.
- R6: A Secure item (`item_ns`=0) that is an ordinary instruction can be traced at EL0, EL1 and EL3, enabled by bits 16, 17 and 19. It is never traced at EL2.
- R7: An ordinary instruction is traced only when bit 9 (start/stop, 1 = started) is 1.
- R8: No item is traced while `trace_en`=0 or `item_valid`=0.
- R9: With `trace_en`=1 and the reset flag low, a system-error item is traced when bit 11 is 1. When bit 11 is 0, it is traced only if the previous valid item was traced. Start/stop and the level mask do not apply.
- R10: With `trace_en`=1, a reset item is traced when bit 10 is 1. When bit 10 is 0, it is traced only if the previous valid item was traced. The reset flag takes precedence over the system-error flag.
- R11: The history bit is cleared while `trace_en`=0. While trace is enabled, every valid item loads the history bit with that item's decision. Invalid cycles leave the history bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Trace unit enable; locks register writes |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| item_valid | input | 1 | An item retires this cycle |
| item_el | input | 2 | Exception level of the item |
| item_ns | input | 1 | 1 = Non-secure, 0 = Secure |
| item_serr | input | 1 | Item is a system-error exception |
| item_rst | input | 1 | Item is a reset exception |
| trace_hit | output | 1 | Item is traced |

## Verification
Random items cover every combination of exception level and security state under random mask words. This separates the two per-state bit maps and shows that the EL3 slot in Non-secure state and the EL2 slot in Secure state never trace. Random items with exception flags, mixed in with ordinary instructions, show whether the overrides follow the history bit or the override bits. Directed sequences cover the following:
- a stopped start/stop state
- writes made during a trace run
- writes to a foreign address
- a traced and an untraced item, each placed before an exception with its override off

Each of these separates a gating condition that random items reach only rarely.

// File: rtl/itrace_filter.sv
module itrace_filter #(
  parameter int          ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              item_valid,
  input  logic [1:0]        item_el,
  input  logic              item_ns,
  input  logic              item_serr,
  input  logic              item_rst,
  output logic              trace_hit
);
  localparam logic [31:0] WMASK = 32'h007B_0EFF;
  localparam int NS_LSB = 20;
  localparam int S_LSB  = 16;
  localparam int SS_BIT = 9;
  localparam int RST_BIT = 10;
  localparam int ERR_BIT = 11;

  logic [31:0] ctl_q;
  logic        last_q;
  logic        sel;
  logic        lvl_ok;
  logic        decide;

  assign sel = (reg_addr == CTL_ADDR);
  assign reg_rdata = sel ? ctl_q : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)                       ctl_q <= 32'd0;
    else if (reg_wen && sel && !trace_en) ctl_q <= reg_wdata & WMASK;
  end

  always_comb begin
    lvl_ok = 1'b0;
    if (item_ns) lvl_ok = (item_el != 2'd3) && ctl_q[NS_LSB + int'(item_el)];
    else         lvl_ok = ctl_q[S_LSB + int'(item_el)];
  end

  always_comb begin
    if (item_rst)       decide = ctl_q[RST_BIT] | last_q;
    else if (item_serr) decide = ctl_q[ERR_BIT] | last_q;
    else                decide = ctl_q[SS_BIT] & lvl_ok;
  end

  assign trace_hit = trace_en & item_valid & decide;

  always_ff @(posedge clk) begin
    if (!rst_n || !trace_en) last_q <= 1'b0;
    else if (item_valid)     last_q <= trace_hit;
  end
endmodule

module itrace_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trace_en,
  input logic        item_valid,
  input logic        item_serr,
  input logic        item_rst,
  input logic        trace_hit,
  input logic [31:0] ctl_q,
  input logic [31:0] reg_rdata,
  input logic        last_q
);
  assert_rdata_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~32'h007B_0EFF) == 32'd0);
  assert_write_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en |=> $stable(ctl_q));
  assert_plain_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_hit && !item_serr && !item_rst) |-> ctl_q[9]);
  assert_hit_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trace_hit |-> (trace_en && item_valid));
  assert_history_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> !last_q);
  assert_history_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && !item_valid) |=> (last_q == $past(last_q)));
endmodule

bind itrace_filter itrace_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .item_valid(item_valid),
  .item_serr(item_serr), .item_rst(item_rst), .trace_hit(trace_hit),
  .ctl_q(ctl_q), .reg_rdata(reg_rdata), .last_q(last_q)
);

// File: tb/itrace_filter_test.sv
module itrace_filter_test;
  localparam logic [31:0] MASK = 32'h007B_0EFF;
  localparam logic [11:0] CA = 12'h080;

  logic clk = 1'b0, rst_n = 1'b0, trace_en = 1'b0, reg_wen = 1'b0;
  logic [11:0] reg_addr = CA;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic item_valid = 1'b0, item_ns = 1'b0, item_serr = 1'b0, item_rst = 1'b0, trace_hit;
  logic [1:0] item_el = '0;

  int vectors = 0, errors = 0;
  logic [31:0] m_ctl = '0;
  logic m_last = 1'b0;

  always #4 clk = ~clk;

  itrace_filter uut (.*);

  function automatic logic lvl(logic [31:0] c, logic [1:0] el, logic ns);
    if (ns) return (el == 2'd3) ? 1'b0 : c[20 + el];
    return (el == 2'd2) ? 1'b0 : c[16 + el];
  endfunction

  function automatic logic exp_hit(logic [31:0] c, logic last, logic en, logic v,
                                   logic [1:0] el, logic ns, logic se, logic rs);
    if (!en || !v) return 1'b0;
    if (rs) return c[10] | last;
    if (se) return c[11] | last;
    return c[9] & lvl(c, el, ns);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic en, logic wen, logic [11:0] a, logic [31:0] wd,
                       logic v, logic [1:0] el, logic ns, logic se, logic rs);
    logic e;
    string t;
    @(negedge clk);
    trace_en = en; reg_wen = wen; reg_addr = a; reg_wdata = wd;
    item_valid = v; item_el = el; item_ns = ns; item_serr = se; item_rst = rs;
    #1;
    e = exp_hit(m_ctl, m_last, en, v, el, ns, se, rs);
    if (tag != "") t = tag;
    else if (!en || !v) t = "R8";
    else if (rs) t = "R10";
    else if (se) t = "R9";
    else if (ns) t = "R5";
    else t = "R6";
    chk(t, {31'd0, trace_hit}, {31'd0, e});
    chk(en ? "R4" : "R2", reg_rdata, (a == CA) ? m_ctl : 32'd0);
    if (wen && a == CA && !en) m_ctl = wd & MASK;
    if (!en) m_last = 1'b0;
    else if (v) m_last = e;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 chk("R1", reg_rdata, 32'd0);
    chk("R1", {31'd0, trace_hit}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    drive("R1", 0, 0, CA, 0, 1, 0, 0, 0, 0);
    // R2: all-ones write keeps only the writable bits
    drive("R2", 0, 1, CA, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    drive("R2", 0, 0, CA, 0, 0, 0, 0, 0, 0);
    // R3: foreign address
    drive("R3", 0, 1, 12'h084, 32'h0, 0, 0, 0, 0, 0);
    drive("R3", 0, 0, 12'h084, 32'h0, 0, 0, 0, 0, 0);
    chk("R3", reg_rdata, 32'd0);
    drive("R3", 0, 0, CA, 0, 0, 0, 0, 0, 0);
    // R4: writes during a run are dropped
    drive("R4", 1, 1, CA, 32'h0, 0, 0, 0, 0, 0);
    drive("R4", 1, 0, CA, 0, 0, 0, 0, 0, 0);
    chk("R4", reg_rdata, MASK);
    // R7: stopped state blocks ordinary items
    drive("R7", 0, 1, CA, 32'h0077_0000, 0, 0, 0, 0, 0);
    drive("R7", 1, 0, CA, 0, 1, 1, 1, 0, 0);
    drive("R7", 1, 0, CA, 0, 1, 0, 0, 0, 0);
    // R11: history drives exceptions when overrides are off
    drive("R11", 0, 1, CA, 32'h0000_0200 | 32'h0010_0000, 0, 0, 0, 0, 0);
    drive("R11", 1, 0, CA, 0, 1, 0, 1, 0, 0);
    drive("R11", 1, 0, CA, 0, 0, 0, 0, 0, 0);
    drive("R11", 1, 0, CA, 0, 1, 0, 0, 1, 0);
    drive("R11", 1, 0, CA, 0, 1, 1, 1, 0, 0);
    drive("R11", 1, 0, CA, 0, 1, 0, 0, 0, 1);
    drive("R11", 1, 0, CA, 0, 1, 0, 1, 0, 0);
    drive("R11", 0, 0, CA, 0, 0, 0, 0, 0, 0);
    drive("R11", 1, 0, CA, 0, 1, 0, 0, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic en, wen, se, rs;
      logic [31:0] r;
      r = $urandom;
      en = (i % 200) >= 40;
      wen = (r[3:0] == 4'd0);
      se = (r[7:5] == 3'd0);
      rs = (r[10:8] == 3'd0);
      drive("", en, wen, r[11] ? CA : {r[19:16], 8'h84},
            $urandom | (r[12] ? 32'h0000_0200 : 32'h0),
            r[13] | r[14], r[21:20], r[22], se, rs);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule